// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block arbitrates five interrupt sources. It takes two external request pins (active low), two timer overflow requests and one serial request. Each source has an enable bit, and all sources share a master enable. Each source also has a one-bit priority. A source whose priority bit is set outranks every source whose bit is clear. Among sources at the same level a fixed source order decides.

Each external pin is synchronised and then passed to its own detector. A mode bit sets that detector to trigger on a falling edge or on a low level. In edge mode the detector latches a pending flag. An acknowledge that names that source clears the flag. The timer and serial requests come in as level signals from their owners, which clear them.

The controller drives a request, the index of the winning source and that source's priority level. A one-cycle acknowledge records the winner's level as in service. An end-of-service pulse removes the most recent level. A high-priority source can interrupt low-priority service. Nothing can interrupt high-priority service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, nothing is in service. With every source idle and the external pins high, `req_o` is 0.
- R2: While `glb_en_i` is 0, `req_o` stays 0, whatever the sources and their individual enables are.
- R3: A source whose bit in `src_en_i` is 0 is never reported in `req_idx_o` while `req_o` is 1.
- R4: Source indices, with bit i of every 5-bit vector belonging to index i, are: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial. Among eligible sources of the same level, the lowest index wins.
- R5: An eligible source with its `prio_hi_i` bit set wins over every source whose bit is clear. `req_lvl_o` is 1 exactly when the winner's priority bit is set.
- R6: In level mode (`ext_type_i` bit = 0), an external source is pending from the second rising edge after its pin goes low. It stops being pending two edges after the pin returns high, so nothing is latched.
- R7: In edge mode (`ext_type_i` bit = 1), a high-to-low transition on the pin sets the pending flag at the third rising edge. The flag stays set after the pin returns high.
- R8: An `ack_i` pulse while `req_o` is 1 and the winner is an edge-mode external source clears that source's flag. An `ack_i` while `req_o` is 0 changes no state.
- R9: While a low-level source is in service, only high-level winners raise `req_o`. While a high-level source is in service, `req_o` stays 0.
- R10: An `eos_i` pulse without an accepted acknowledge removes the high level from service if it is present, and otherwise removes the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_n_i | input | 2 | External request pins, active low, asynchronous |
| tmr_req_i | input | 2 | Timer 0 and timer 1 overflow requests, level |
| ser_req_i | input | 1 | Serial request, level |
| ext_type_i | input | 2 | Per pin: 1 = falling-edge mode, 0 = low-level mode |
| src_en_i | input | 5 | Per-source enable, indexed as in R4 |
| glb_en_i | input | 1 | Master enable |
| prio_hi_i | input | 5 | Per-source priority, 1 = high level |
| ack_i | input | 1 | One-cycle acknowledge of the current winner |
| eos_i | input | 1 | One-cycle end of service |
| req_o | output | 1 | Interrupt request |
| req_idx_o | output | 3 | Winning source index |
| req_lvl_o | output | 1 | Winning source priority level |

## Verification
A random phase drives the timer and serial requests, the enables and the priority bits at random. It mixes in random acknowledge and end-of-service pulses, which tests the order and level rules against every state of the in-service stack. Directed cases target the external detectors. Holding a pin low and then releasing it separates level mode from edge mode, because only edge mode keeps the flag. An acknowledge sent while no request is active shows whether idle acknowledges are ignored. Running a low acknowledge, then a high acknowledge, then two end-of-service pulses separates preemption from plain nesting.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_EXT = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);
  typedef logic [IDX_W-1:0] src_idx_t;
  // source slot of each external pin in the fixed order
  localparam int EXT_SLOT [NUM_EXT] = '{0, 2};
  localparam int TMR_SLOT [2]       = '{1, 3};
  localparam int SER_SLOT           = 4;
endpackage

// File: rtl/ext_detect.sv
module ext_detect #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  localparam int TOP = SYNC - 1;
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            flag_q;
  logic            fall;

  assign fall = prev_q & ~sync_q[TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_n};
      prev_q <= sync_q[TOP];
      if (!edge_mode)  flag_q <= 1'b0;
      else if (fall)   flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
    end
  end

  assign pend = edge_mode ? flag_q : ~sync_q[TOP];
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  eligible,
  input  logic [N-1:0]  hi_mask,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          lvl
);
  logic [N-1:0] hi_set;
  logic [N-1:0] use_set;

  always_comb begin
    hi_set  = eligible & hi_mask;
    use_set = (|hi_set) ? hi_set : eligible;
    idx     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (use_set[i]) idx = i[IW-1:0];
    end
    any = |eligible;
    lvl = |hi_set;
  end
endmodule

// File: rtl/svc_level.sv
module svc_level (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic ins_hi,
  output logic ins_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (push) begin
      if (push_hi) ins_hi <= 1'b1;
      else         ins_lo <= 1'b1;
    end else if (pop) begin
      if (ins_hi)  ins_hi <= 1'b0;
      else         ins_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_n_i,
  input  logic [1:0]         tmr_req_i,
  input  logic               ser_req_i,
  input  logic [NUM_EXT-1:0] ext_type_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   req_idx_o,
  output logic               req_lvl_o
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] eligible;
  logic               any;
  logic               ins_hi, ins_lo;
  logic               allow;
  logic               ack_ok;

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : g_ext
      logic clr;
      assign clr = ack_ok && (req_idx_o == src_idx_t'(EXT_SLOT[g]));
      ext_detect #(.SYNC(SYNC)) u_det (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_n_i[g]),
        .edge_mode (ext_type_i[g]),
        .clr       (clr),
        .pend      (pend[EXT_SLOT[g]])
      );
    end
    for (g = 0; g < 2; g++) begin : g_tmr
      assign pend[TMR_SLOT[g]] = tmr_req_i[g];
    end
  endgenerate
  assign pend[SER_SLOT] = ser_req_i;

  assign eligible = pend & src_en_i & {NUM_SRC{glb_en_i}};

  prio_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
    .eligible (eligible),
    .hi_mask  (prio_hi_i),
    .any      (any),
    .idx      (req_idx_o),
    .lvl      (req_lvl_o)
  );

  assign allow  = ~ins_hi & (~ins_lo | req_lvl_o);
  assign req_o  = any & allow;
  assign ack_ok = ack_i & req_o;

  svc_level u_svc (
    .clk     (clk),
    .rst     (rst),
    .push    (ack_ok),
    .push_hi (req_lvl_o),
    .pop     (eos_i),
    .ins_hi  (ins_hi),
    .ins_lo  (ins_lo)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               glb_en_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic [NUM_SRC-1:0] prio_hi_i,
  input logic               req_o,
  input logic [IDX_W-1:0]   req_idx_o,
  input logic               req_lvl_o,
  input logic               ack_i,
  input logic               eos_i,
  input logic               ins_hi,
  input logic               ins_lo
);
  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |-> !req_o);
  // R3
  src_en_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> src_en_i[req_idx_o]);
  // R5
  lvl_match_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (req_lvl_o == prio_hi_i[req_idx_o]));
  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    ins_hi |-> !req_o);
  // R9
  lo_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_lo && req_o) |-> req_lvl_o);
  // R10
  eos_pop_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_hi && eos_i && !(ack_i && req_o)) |=> !ins_hi);
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .glb_en_i  (glb_en_i),
  .src_en_i  (src_en_i),
  .prio_hi_i (prio_hi_i),
  .req_o     (req_o),
  .req_idx_o (req_idx_o),
  .req_lvl_o (req_lvl_o),
  .ack_i     (ack_i),
  .eos_i     (eos_i),
  .ins_hi    (ins_hi),
  .ins_lo    (ins_lo)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] ext_n, ext_type, tmr;
  logic       ser, glb, ack, eos;
  logic [4:0] en, prio;
  logic       req_o, req_lvl_o;
  logic [2:0] req_idx_o;
  int         n_vec = 0, n_bad = 0;
  logic       m_hi = 1'b0, m_lo = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_n_i(ext_n), .tmr_req_i(tmr), .ser_req_i(ser),
    .ext_type_i(ext_type), .src_en_i(en), .glb_en_i(glb), .prio_hi_i(prio),
    .ack_i(ack), .eos_i(eos), .req_o(req_o), .req_idx_o(req_idx_o),
    .req_lvl_o(req_lvl_o)
  );

  // expected {req, idx[2:0], lvl}
  function automatic logic [4:0] model(input logic [4:0] pend, input logic [4:0] e,
                                       input logic g, input logic [4:0] p,
                                       input logic shi, input logic slo);
    logic [4:0] ok;
    ok = pend & e & {5{g}};
    for (int lv = 1; lv >= 0; lv--) begin
      for (int i = 0; i < 5; i++) begin
        if (ok[i] && (p[i] == lv[0])) begin
          if (shi) return 5'b0;
          if (slo && lv == 0) return 5'b0;
          return {1'b1, i[2:0], lv[0]};
        end
      end
    end
    return 5'b0;
  endfunction

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {req_o, req_idx_o, req_lvl_o};
    if (!req_o) act[3:0] = 4'b0;
    if (!exp[4]) exp[3:0] = 4'b0;
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got req/idx/lvl=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; edges(1); ack = 1'b0;
  endtask

  task automatic pulse_eos();
    eos = 1'b1; edges(1); eos = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ext_n = 2'b11; ext_type = 2'b00; tmr = 0; ser = 0;
    glb = 0; en = 0; prio = 0; ack = 0; eos = 0; rst = 1'b1;
    edges(3);
    rst = 1'b0;
    edges(1);
    // R1 reset state: no request
    chk("R1 reset", 5'b0);

    // R2 master enable gates all
    tmr = 2'b11; ser = 1; en = 5'h1f; glb = 0; #1;
    chk("R2 global off", 5'b0);
    glb = 1; #1;
    // R4 timer0 (index 1) wins among 1,3,4
    chk("R4 order", {1'b1, 3'd1, 1'b0});
    // R3 disable timer0 -> timer1
    en = 5'b11101; #1;
    chk("R3 enable mask", {1'b1, 3'd3, 1'b0});
    // R5 serial high beats timer
    prio = 5'b10000; #1;
    chk("R5 high level", {1'b1, 3'd4, 1'b1});
    tmr = 0; ser = 0; prio = 0; en = 5'h1f;

    // R6 level mode on pin 0
    @(negedge clk); ext_n[0] = 0;
    edges(1); chk("R6 not yet", 5'b0);
    edges(1); chk("R6 low level", {1'b1, 3'd0, 1'b0});
    ext_n[0] = 1; edges(2);
    chk("R6 not latched", 5'b0);

    // R7 edge mode on pin 1 (index 2)
    ext_type = 2'b10; edges(1);
    ext_n[1] = 0; edges(2);
    chk("R7 before flag", 5'b0);
    edges(1);
    chk("R7 flag set", {1'b1, 3'd2, 1'b0});
    ext_n[1] = 1; edges(4);
    chk("R7 held", {1'b1, 3'd2, 1'b0});
    // R8 acknowledge clears flag (low level now in service)
    pulse_ack();
    chk("R8 flag cleared", 5'b0);
    pulse_eos();
    chk("R8 still clear", 5'b0);

    // R8 ack without request is ignored: no level pushed
    en = 0; pulse_ack(); en = 5'h1f; tmr = 2'b01; #1;
    chk("R8 idle ack", {1'b1, 3'd1, 1'b0});

    // R9 nesting: low in service blocks low, admits high
    pulse_ack();
    chk("R9 low blocks low", 5'b0);
    ser = 1; prio = 5'b10000; #1;
    chk("R9 high preempts", {1'b1, 3'd4, 1'b1});
    pulse_ack();
    chk("R9 high blocks all", 5'b0);
    // R10 pop high, then low
    pulse_eos();
    chk("R10 pop high", {1'b1, 3'd4, 1'b1});
    ser = 0; #1;
    chk("R10 low still held", 5'b0);
    pulse_eos();
    chk("R10 pop low", {1'b1, 3'd1, 1'b0});
    tmr = 0; prio = 0; ext_type = 0;

    // random phase, externals idle
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] exp;
      logic [31:0] r;
      r = $urandom;
      tmr = r[1:0]; ser = r[2]; en = r[7:3]; prio = r[12:8];
      glb = (r[15:13] != 0);
      #1;
      exp = model({ser, tmr[1], 1'b0, tmr[0], 1'b0}, en, glb, prio, m_hi, m_lo);
      chk("R4/R5/R9 random", exp);
      ack = (r[19:17] == 0);
      eos = (r[22:20] < 2);
      @(posedge clk);
      if (ack && exp[4]) begin
        if (exp[0]) m_hi = 1'b1; else m_lo = 1'b1;
      end else if (eos) begin
        if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
      end
      @(negedge clk);
      ack = 0; eos = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule